// File: doc/BRIEF.md
# Grouped Carry-Lookahead Adder

This block adds two unsigned operands and an incoming carry in one combinational pass. It returns the sum and the outgoing carry. For each bit it forms a generate term (both operand bits set) and a propagate term (at least one operand bit set). The bits are split into fixed-size groups. Inside a group, every carry is a flat two-level sum of products built from those terms and the group's incoming carry, so no carry waits on its neighbour inside the group. Between groups the carry passes from one group to the next in a chain. This keeps each group small and identical, and the critical path grows with the number of groups rather than the number of bits.

Each group also drives a group-generate flag and a group-propagate flag. A second lookahead level placed above the adder can use these flags to compute the group carries in parallel.

Top module: `cla_adder`

## Requirements
- R1: For every input, the concatenation {carry_out, sum} equals the unsigned value operand_a + operand_b + carry_in.
- R2: carry_out is 1 exactly when operand_a + operand_b + carry_in exceeds 2^WIDTH - 1.
- R3: Inside a group, the carry into bit j+1 equals gen_j OR (prop_j AND carry into bit j). Here gen_j = a_j AND b_j and prop_j = a_j OR b_j. The carry into the group's lowest bit is the group's incoming carry.
- R4: Each sum bit equals a_i XOR b_i XOR the carry into bit i.
- R5: Group k covers bits k*GROUP through k*GROUP+GROUP-1. Its bit grp_gen[k] is 1 exactly when that slice of operand_a plus that slice of operand_b, with no incoming carry, reaches 2^GROUP or more.
- R6: grp_prop[k] is 1 exactly when every bit position of group k has a 1 in operand_a or operand_b (inclusive OR). It is not 1 only when every position holds exactly one 1.
- R7: The carry leaving group k equals grp_gen[k] OR (grp_prop[k] AND the carry entering group k). carry_out is the carry leaving the most significant group.
- R8: An all-ones operand plus a carry of 1 into bit 0 wraps the sum to zero with carry_out 1. The carry reaches carry_out through every group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| operand_a | input | WIDTH | First addend |
| operand_b | input | WIDTH | Second addend |
| carry_in | input | 1 | Carry into bit 0 |
| sum | output | WIDTH | Low WIDTH bits of the total |
| carry_out | output | 1 | Carry out of the top bit |
| grp_gen | output | WIDTH/GROUP | Per-group generate flag, bit k for group k |
| grp_prop | output | WIDTH/GROUP | Per-group propagate flag, bit k for group k |

## Verification
Random operand pairs with a random incoming carry exercise the sum, the carry-out and both group flags against arithmetic reference models. Zero plus zero shows that nothing is generated when no bit is set.

Alternating patterns such as 0x5555_5555 plus 0xAAAA_AAAA have every position propagating and none generating. With a carry in of 1 they force the longest chain through all groups, which exposes a broken chain between groups. They also set every group-propagate flag, which tells the inclusive-OR form apart from an XOR form only when a position has both operand bits set. The all-ones-plus-one and all-ones-plus-all-ones cases mix generate and propagate in one group, which separates the two forms.

// File: rtl/cla_pkg.sv
package cla_pkg;
    parameter int unsigned CLA_WIDTH_DEF = 32;
    parameter int unsigned CLA_GROUP_DEF = 4;

    typedef struct packed {
        logic gen;
        logic prop;
    } bit_term_t;
endpackage

// File: rtl/cla_term_cells.sv
module cla_term_cells
    import cla_pkg::*;
#(
    parameter int unsigned WIDTH = CLA_WIDTH_DEF
) (
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    output logic [WIDTH-1:0] gen,
    output logic [WIDTH-1:0] prop
);
    bit_term_t terms [WIDTH];

    for (genvar i = 0; i < WIDTH; i++) begin : g_cell
        assign terms[i].gen  = op_a[i] & op_b[i];
        assign terms[i].prop = op_a[i] | op_b[i];
        assign gen[i]        = terms[i].gen;
        assign prop[i]       = terms[i].prop;
    end
endmodule

// File: rtl/cla_group.sv
module cla_group
    import cla_pkg::*;
#(
    parameter int unsigned GROUP = CLA_GROUP_DEF
) (
    input  logic [GROUP-1:0] gen,
    input  logic [GROUP-1:0] prop,
    input  logic             grp_cin,
    output logic [GROUP-1:0] bit_carry,
    output logic             grp_cout,
    output logic             grp_g,
    output logic             grp_p
);
    logic [GROUP-1:0] c_next;

    // Each carry is a flat OR of AND terms over the group's own g/p and cin.
    always_comb begin
        logic prod;
        c_next = '0;
        grp_g  = 1'b0;
        for (int j = 0; j < GROUP; j++) begin
            for (int k = 0; k <= j; k++) begin
                prod = gen[k];
                for (int m = k + 1; m <= j; m++) prod = prod & prop[m];
                c_next[j] = c_next[j] | prod;
                if (j == GROUP - 1) grp_g = grp_g | prod;
            end
            prod = grp_cin;
            for (int m = 0; m <= j; m++) prod = prod & prop[m];
            c_next[j] = c_next[j] | prod;
        end
        grp_p = &prop;
    end

    assign bit_carry = {c_next[GROUP-2:0], grp_cin};
    assign grp_cout  = c_next[GROUP-1];

    always_comb begin
        for (int j = 0; j + 1 < GROUP; j++) begin
            AST_CARRY_RECUR: assert (bit_carry[j+1] == (gen[j] | (prop[j] & bit_carry[j]))) else $error("carry recurrence"); // R3
        end
        AST_GROUP_COUT: assert (grp_cout == (grp_g | (grp_p & grp_cin))) else $error("group carry out"); // R7
        AST_GEN_FORCES: assert (!grp_g || grp_cout) else $error("generate without carry"); // R5
    end
endmodule

// File: rtl/cla_sum_stage.sv
module cla_sum_stage
    import cla_pkg::*;
#(
    parameter int unsigned WIDTH = CLA_WIDTH_DEF
) (
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic [WIDTH-1:0] carry,
    output logic [WIDTH-1:0] sum
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_sum
        assign sum[i] = op_a[i] ^ op_b[i] ^ carry[i];
    end
endmodule

// File: rtl/cla_adder.sv
module cla_adder
    import cla_pkg::*;
#(
    parameter int unsigned WIDTH = CLA_WIDTH_DEF,
    parameter int unsigned GROUP = CLA_GROUP_DEF
) (
    input  logic [WIDTH-1:0]       operand_a,
    input  logic [WIDTH-1:0]       operand_b,
    input  logic                   carry_in,
    output logic [WIDTH-1:0]       sum,
    output logic                   carry_out,
    output logic [WIDTH/GROUP-1:0] grp_gen,
    output logic [WIDTH/GROUP-1:0] grp_prop
);
    localparam int unsigned NGRP = WIDTH / GROUP;

    if (GROUP < 2 || (WIDTH % GROUP) != 0) begin : g_bad_cfg
        $error("WIDTH must be a multiple of GROUP and GROUP at least 2");
    end

    logic [WIDTH-1:0] gen;
    logic [WIDTH-1:0] prop;
    logic [WIDTH-1:0] carry;
    logic [NGRP:0]    chain;

    cla_term_cells #(.WIDTH(WIDTH)) u_terms (
        .op_a (operand_a),
        .op_b (operand_b),
        .gen  (gen),
        .prop (prop)
    );

    assign chain[0] = carry_in;

    for (genvar k = 0; k < NGRP; k++) begin : g_grp
        cla_group #(.GROUP(GROUP)) u_grp (
            .gen       (gen[k*GROUP +: GROUP]),
            .prop      (prop[k*GROUP +: GROUP]),
            .grp_cin   (chain[k]),
            .bit_carry (carry[k*GROUP +: GROUP]),
            .grp_cout  (chain[k+1]),
            .grp_g     (grp_gen[k]),
            .grp_p     (grp_prop[k])
        );
    end

    cla_sum_stage #(.WIDTH(WIDTH)) u_sum (
        .op_a  (operand_a),
        .op_b  (operand_b),
        .carry (carry),
        .sum   (sum)
    );

    assign carry_out = chain[NGRP];

    always_comb begin
        logic [WIDTH:0] total;
        total = {1'b0, operand_a} + {1'b0, operand_b} + {{WIDTH{1'b0}}, carry_in};
        AST_SUM_EXACT: assert ({carry_out, sum} == total) else $error("sum mismatch"); // R1
        AST_COUT_RANGE: assert (carry_out == total[WIDTH]) else $error("carry out"); // R2
        AST_SUM_BITS: assert ((sum ^ operand_a ^ operand_b) == carry) else $error("sum bits"); // R4
        AST_PROP_COVER: assert (!(&(operand_a | operand_b)) || (&grp_prop)) else $error("prop flags"); // R6
    end
endmodule

// File: tb/tb_cla_adder.sv
module tb_cla_adder;
    localparam int W  = 32;
    localparam int G  = 4;
    localparam int NG = W / G;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic [W-1:0]  a, b, s;
    logic          ci, co;
    logic [NG-1:0] gg, gp;

    int checks = 0;
    int errors = 0;

    cla_adder #(.WIDTH(W), .GROUP(G)) dut (
        .operand_a (a), .operand_b (b), .carry_in (ci),
        .sum (s), .carry_out (co), .grp_gen (gg), .grp_prop (gp)
    );

    function automatic logic [W:0] ref_total(logic [W-1:0] x, logic [W-1:0] y, logic c);
        return {1'b0, x} + {1'b0, y} + {{W{1'b0}}, c};
    endfunction

    function automatic logic [NG-1:0] ref_gen(logic [W-1:0] x, logic [W-1:0] y);
        logic [NG-1:0] r;
        for (int k = 0; k < NG; k++)
            r[k] = ({1'b0, x[k*G +: G]} + {1'b0, y[k*G +: G]}) >= (G+1)'(1 << G);
        return r;
    endfunction

    function automatic logic [NG-1:0] ref_prop(logic [W-1:0] x, logic [W-1:0] y);
        logic [NG-1:0] r;
        for (int k = 0; k < NG; k++) r[k] = &(x[k*G +: G] | y[k*G +: G]);
        return r;
    endfunction

    // carry entering the top group, from low-slice arithmetic
    function automatic logic ref_top_cin(logic [W-1:0] x, logic [W-1:0] y, logic c);
        logic [W-G:0] t;
        t = {1'b0, x[W-G-1:0]} + {1'b0, y[W-G-1:0]} + {{(W-G){1'b0}}, c};
        return t[W-G];
    endfunction

    task automatic check(string tag, logic [W:0] act, logic [W:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic apply(logic [W-1:0] x, logic [W-1:0] y, logic c);
        logic [W:0] t;
        logic       tc;
        @(posedge clk);
        a = x; b = y; ci = c;
        @(negedge clk);
        t = ref_total(x, y, c);
        check("R1 R3 R4 sum", {1'b0, s}, {1'b0, t[W-1:0]});
        check("R2 carry_out", {{W{1'b0}}, co}, {{W{1'b0}}, t[W]});
        check("R5 grp_gen", (W+1)'(gg), (W+1)'(ref_gen(x, y)));
        check("R6 grp_prop", (W+1)'(gp), (W+1)'(ref_prop(x, y)));
        tc = ref_top_cin(x, y, c);
        check("R7 top group carry", {{W{1'b0}}, co},
              {{W{1'b0}}, ref_gen(x, y)[NG-1] | (ref_prop(x, y)[NG-1] & tc)});
    endtask

    initial begin
        #3_000_000;
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int seed;
        a = '0; b = '0; ci = 1'b0;
        seed = 32'h1A2B3C4D;
        void'($urandom(seed));
        apply('0, '0, 1'b0);                          // zero plus zero
        apply('1, 32'd1, 1'b0);                       // R8 wraps via b
        apply('1, '0, 1'b1);                          // R8 wraps via carry_in
        check("R8 wrap to zero", {co, s}, {1'b1, {W{1'b0}}});
        apply('1, '1, 1'b1);                          // generate everywhere
        apply(32'h5555_5555, 32'hAAAA_AAAA, 1'b1);    // full propagate chain
        apply(32'h5555_5555, 32'hAAAA_AAAA, 1'b0);
        apply(32'h0000_000F, 32'h0000_0001, 1'b0);    // OR-vs-XOR propagate
        apply(32'h8000_0000, 32'h8000_0000, 1'b0);    // top generate only
        for (int i = 0; i < 400; i++) begin
            logic [W-1:0] x, y;
            x = $urandom();
            y = $urandom();
            if (i % 4 == 0) y = ~x;                   // bias toward long propagation
            apply(x, y, 1'($urandom() & 1));
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule